// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous page-mode DRAM alive by issuing refresh cycles at a steady average rate. A free-running interval timer adds one refresh to a saturating backlog counter each time it expires. While refreshes are owed, the block raises a request toward the access controller that owns the RAS/CAS strobes. Once granted, it runs one complete, correctly timed refresh cycle for each owed refresh.

Three cycle styles are supported. In CAS-before-RAS mode, CAS goes low before RAS falls, and the DRAM picks the row from its own internal counter. In RAS-only mode, the block drives a row address from its own counter with CAS held high, and advances that counter after each cycle. In hidden mode, the access controller is holding a read with CAS low. The block keeps CAS low, returns RAS high for the precharge time and then pulls RAS low again, which performs a counter-addressed refresh while the read data stays valid.

The refresh interval depends on the mode. Counter-addressed styles need only half as many cycles per retention period as the RAS-only style. A low-power strap doubles the retention period and so halves the rate. When the backlog is full, the block asks the access controller to close its open page.

Top module: `refsch_top`

## Requirements
- R1: After reset, ras_n_o and cas_n_o are 1, row_en_o is 0, ref_req_o is 0, force_close_o is 0, pending_o is 0 and row_o is 0.
- R2: With mode_i = 0 (CAS-before-RAS) and low_pwr_i = 0, pending_o rises once every CLK_KHZ*PERIOD_MS/ROWS_CBR clock cycles. Encoding 3 behaves as 0.
- R3: With mode_i = 1 (RAS-only) and low_pwr_i = 0, pending_o rises once every CLK_KHZ*PERIOD_MS/ROWS_ROR clock cycles.
- R4: With low_pwr_i = 1, the interval for the selected mode is twice the R2/R3 value.
- R5: pending_o never exceeds BURST. While it equals BURST, force_close_o is 1, and further timer expiries leave it at BURST.
- R6: ref_req_o is 1 while refreshes are owed or a cycle is in progress. No refresh cycle starts while ref_gnt_i is 0.
- R7: A CAS-before-RAS cycle (mode_i = 0, latched at start) holds CAS low for at least T_CSR cycles before RAS falls and keeps row_en_o at 0.
- R8: A RAS-only cycle (mode_i = 1) keeps CAS high and row_en_o at 1 while RAS is low and presents row_o. row_o increments by one after each such cycle.
- R9: A hidden cycle (mode_i = 2) starts only while rd_hold_i is 1. CAS stays low through precharge, the RAS-low phase and RAS rise.
- R10: Every refresh cycle holds RAS low for exactly T_RC - T_RP cycles, and RAS is high for at least T_RP cycles before it falls.
- R11: Each finished cycle lowers pending_o by one. When the backlog is served, pending_o returns to 0 and ref_req_o returns to 0.
- R12: In modes 0 and 1, a granted cycle starts only while ctrl_idle_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Refresh style: 0 CAS-before-RAS, 1 RAS-only, 2 hidden |
| low_pwr_i | input | 1 | Extended retention part: doubles the interval |
| ctrl_idle_i | input | 1 | Access controller idle with page closed |
| rd_hold_i | input | 1 | Access controller holds a read with CAS low |
| ref_gnt_i | input | 1 | Strobe bus granted to the scheduler |
| ref_req_o | output | 1 | Strobe bus request |
| force_close_o | output | 1 | Backlog full; open page must close |
| pending_o | output | $clog2(BURST+1) | Owed refresh count |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| row_en_o | output | 1 | Drive row_o onto the address bus |
| row_o | output | $clog2(ROWS_ROR) | RAS-only row address |

## Verification
If the interval timer holds the wrong limit, the spacing between pending_o increments differs from the computed interval on the very next period. A wrong backlog count shows up as a missing or extra RAS fall during a drain, or as force_close_o at the wrong level. A bad sequencer state shows up within one refresh cycle, as a wrong CAS level at the RAS fall or a wrong RAS-low width. A wrong row counter shows up at the next RAS-only cycle, where the scoreboard compares the presented row with its own running count.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [1:0] {
    MODE_CBR = 2'd0,
    MODE_ROR = 2'd1,
    MODE_HID = 2'd2,
    MODE_RSV = 2'd3
  } ref_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_CSR  = 3'd2,
    ST_ACT  = 3'd3,
    ST_END  = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic addr_en;
  } strobe_t;

  function automatic ref_mode_e norm_mode(input logic [1:0] m);
    ref_mode_e r;
    unique case (m)
      2'd1:    r = MODE_ROR;
      2'd2:    r = MODE_HID;
      default: r = MODE_CBR;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/refsch_tick.sv
module refsch_tick #(
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned PERIOD_MS = 64,
  parameter int unsigned ROWS_CBR  = 4096,
  parameter int unsigned ROWS_ROR  = 8192
) (
  input  logic                  clk,
  input  logic                  rst,
  input  refsch_pkg::ref_mode_e mode,
  input  logic                  low_pwr,
  output logic                  tick
);
  import refsch_pkg::*;

  localparam int unsigned IV_CBR = (CLK_KHZ * PERIOD_MS) / ROWS_CBR;
  localparam int unsigned IV_ROR = (CLK_KHZ * PERIOD_MS) / ROWS_ROR;
  localparam int unsigned IV_MAX = 2 * ((IV_CBR > IV_ROR) ? IV_CBR : IV_ROR);
  localparam int          CW     = $clog2(IV_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          tick_q;

  always_comb begin
    int unsigned base;
    base = (mode == MODE_ROR) ? IV_ROR : IV_CBR;
    lim  = low_pwr ? CW'(2 * base) : CW'(base);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= lim - CW'(1)) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q)
    else $error("tick pulses back to back");

endmodule

// File: rtl/refsch_pend.sv
module refsch_pend #(
  parameter int unsigned BURST = 8,
  localparam int         PW    = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          done,
  output logic [PW-1:0] count,
  output logic          full
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          full_q;
  logic          inc, dec;

  always_comb begin
    inc   = tick && ((cnt_q != PW'(BURST)) || done);
    dec   = done && (cnt_q != '0);
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + PW'(1);
    else if (dec && !inc) cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == PW'(BURST));
    end
  end

  assign count = cnt_q;
  assign full  = full_q;

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= PW'(BURST))
    else $error("backlog above limit");

  p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == PW'(BURST) && tick && !done) |=> (cnt_q == PW'(BURST)))
    else $error("saturated backlog moved");

  p_done_dec_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - PW'(1)))
    else $error("finished cycle did not lower backlog");

endmodule

// File: rtl/refsch_seq.sv
module refsch_seq #(
  parameter int unsigned T_RP  = 4,
  parameter int unsigned T_RC  = 11,
  parameter int unsigned T_CSR = 1,
  parameter int unsigned ROW_W = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  refsch_pkg::ref_mode_e mode,
  input  logic                  gnt,
  input  logic                  ctrl_idle,
  input  logic                  rd_hold,
  input  logic                  owed,
  output logic                  ras_n,
  output logic                  cas_n,
  output logic                  addr_en,
  output logic [ROW_W-1:0]      row,
  output logic                  done,
  output logic                  busy
);
  import refsch_pkg::*;

  localparam int unsigned T_RAS = T_RC - T_RP;
  localparam int unsigned T_MX0 = (T_RP > T_RAS) ? T_RP : T_RAS;
  localparam int unsigned T_MAX = (T_MX0 > T_CSR) ? T_MX0 : T_CSR;
  localparam int          TW    = $clog2(T_MAX + 1);

  seq_st_e        st_q, st_d;
  ref_mode_e      cm_q, cm_d;
  logic [TW-1:0]  tmr_q, tmr_d;
  logic [ROW_W-1:0] row_q;
  strobe_t        stb_q, stb_d;
  logic           may_start;

  function automatic strobe_t drive(input seq_st_e s, input ref_mode_e m);
    strobe_t o;
    o.ras_n   = (s != ST_ACT);
    o.addr_en = 1'b0;
    o.cas_n   = 1'b1;
    unique case (m)
      MODE_CBR: o.cas_n = !(s == ST_CSR || s == ST_ACT);
      MODE_HID: o.cas_n = (s == ST_IDLE);
      MODE_ROR: o.addr_en = (s != ST_IDLE);
      default:  o.cas_n = 1'b1;
    endcase
    return o;
  endfunction

  always_comb begin
    may_start = owed && gnt && ((mode == MODE_HID) ? rd_hold : ctrl_idle);
    st_d  = st_q;
    cm_d  = cm_q;
    tmr_d = tmr_q;
    unique case (st_q)
      ST_IDLE: if (may_start) begin
        st_d  = ST_PRE;
        cm_d  = mode;
        tmr_d = TW'(T_RP - 1);
      end
      ST_PRE: begin
        if (tmr_q == '0) begin
          if (cm_q == MODE_CBR) begin
            st_d  = ST_CSR;
            tmr_d = TW'(T_CSR - 1);
          end else begin
            st_d  = ST_ACT;
            tmr_d = TW'(T_RAS - 1);
          end
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      ST_CSR: begin
        if (tmr_q == '0) begin
          st_d  = ST_ACT;
          tmr_d = TW'(T_RAS - 1);
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      ST_ACT: begin
        if (tmr_q == '0) st_d = ST_END;
        else             tmr_d = tmr_q - TW'(1);
      end
      ST_END:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    stb_d = drive(st_d, cm_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cm_q  <= MODE_CBR;
      tmr_q <= '0;
      row_q <= '0;
      stb_q <= '{ras_n: 1'b1, cas_n: 1'b1, addr_en: 1'b0};
    end else begin
      st_q  <= st_d;
      cm_q  <= cm_d;
      tmr_q <= tmr_d;
      stb_q <= stb_d;
      if (st_q == ST_END && cm_q == MODE_ROR) row_q <= row_q + ROW_W'(1);
    end
  end

  assign ras_n   = stb_q.ras_n;
  assign cas_n   = stb_q.cas_n;
  assign addr_en = stb_q.addr_en;
  assign row     = row_q;
  assign done    = (st_q == ST_END);
  assign busy    = (st_q != ST_IDLE);

  // checker state: length of the current RAS-low run
  logic [TW:0] low_run;
  always_ff @(posedge clk) begin
    if (rst)        low_run <= '0;
    else if (ras_n) low_run <= '0;
    else            low_run <= low_run + 1'b1;
  end

  p_ras_width_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_run == (TW+1)'(T_RAS)))
    else $error("RAS low width wrong");

  p_cbr_order_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && cm_q == MODE_CBR) |-> (!cas_n && $past(!cas_n)))
    else $error("CAS not ahead of RAS");

  p_ror_cas_r8: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && cm_q == MODE_ROR) |-> (cas_n && addr_en))
    else $error("RAS-only cycle touched CAS or dropped address");

  p_hid_cas_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cm_q == MODE_HID) |-> !cas_n)
    else $error("hidden cycle released CAS");

  p_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(gnt && owed))
    else $error("cycle began without grant");

  p_row_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_q) |-> (row_q == $past(row_q) + ROW_W'(1)))
    else $error("row counter jumped");

endmodule

// File: rtl/refsch_top.sv
module refsch_top #(
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned PERIOD_MS = 64,
  parameter int unsigned ROWS_CBR  = 4096,
  parameter int unsigned ROWS_ROR  = 8192,
  parameter int unsigned BURST     = 8,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_RC      = 11,
  parameter int unsigned T_CSR     = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    mode_i,
  input  logic                          low_pwr_i,
  input  logic                          ctrl_idle_i,
  input  logic                          rd_hold_i,
  input  logic                          ref_gnt_i,
  output logic                          ref_req_o,
  output logic                          force_close_o,
  output logic [$clog2(BURST+1)-1:0]    pending_o,
  output logic                          ras_n_o,
  output logic                          cas_n_o,
  output logic                          row_en_o,
  output logic [$clog2(ROWS_ROR)-1:0]   row_o
);
  import refsch_pkg::*;

  localparam int PW    = $clog2(BURST + 1);
  localparam int ROW_W = $clog2(ROWS_ROR);

  ref_mode_e    mode_n;
  logic         tick, done, busy, full;
  logic [PW-1:0] pend;
  logic         req_q;

  assign mode_n = norm_mode(mode_i);

  refsch_tick #(
    .CLK_KHZ(CLK_KHZ), .PERIOD_MS(PERIOD_MS),
    .ROWS_CBR(ROWS_CBR), .ROWS_ROR(ROWS_ROR)
  ) u_tick (
    .clk(clk), .rst(rst), .mode(mode_n), .low_pwr(low_pwr_i), .tick(tick)
  );

  refsch_pend #(.BURST(BURST)) u_pend (
    .clk(clk), .rst(rst), .tick(tick), .done(done),
    .count(pend), .full(full)
  );

  refsch_seq #(
    .T_RP(T_RP), .T_RC(T_RC), .T_CSR(T_CSR), .ROW_W(ROW_W)
  ) u_seq (
    .clk(clk), .rst(rst), .mode(mode_n), .gnt(ref_gnt_i),
    .ctrl_idle(ctrl_idle_i), .rd_hold(rd_hold_i), .owed(pend != '0),
    .ras_n(ras_n_o), .cas_n(cas_n_o), .addr_en(row_en_o), .row(row_o),
    .done(done), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= (pend != '0) || busy;
  end

  assign ref_req_o     = req_q;
  assign force_close_o = full;
  assign pending_o     = pend;

  p_idle_gate_r12: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n_o) && cas_n_o) |-> $past(ctrl_idle_i, T_RP + 1))
    else $error("RAS-only cycle started while controller busy");

endmodule

// File: tb/refsch_top_tb.sv
module refsch_top_tb;
  localparam int unsigned CLK_KHZ = 1000, PERIOD_MS = 1;
  localparam int unsigned ROWS_CBR = 16, ROWS_ROR = 32, BURST = 4;
  localparam int unsigned T_RP = 2, T_RC = 5, T_CSR = 1;
  localparam int IV_CBR = CLK_KHZ * PERIOD_MS / ROWS_CBR;
  localparam int IV_ROR = CLK_KHZ * PERIOD_MS / ROWS_ROR;
  localparam int T_RAS  = T_RC - T_RP;

  logic clk = 0, rst = 1;
  logic [1:0] mode_i = 0;
  logic low_pwr_i = 0, ctrl_idle_i = 0, rd_hold_i = 0, ref_gnt_i = 0;
  logic ref_req_o, force_close_o, ras_n_o, cas_n_o, row_en_o;
  logic [$clog2(BURST+1)-1:0] pending_o;
  logic [$clog2(ROWS_ROR)-1:0] row_o;

  int checks = 0, errors = 0, falls = 0, cyc = 0;

  typedef struct { int mode; int row; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  refsch_top #(
    .CLK_KHZ(CLK_KHZ), .PERIOD_MS(PERIOD_MS), .ROWS_CBR(ROWS_CBR),
    .ROWS_ROR(ROWS_ROR), .BURST(BURST), .T_RP(T_RP), .T_RC(T_RC), .T_CSR(T_CSR)
  ) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_exp(input int m, input int r);
    exp_t e;
    e.mode = m; e.row = r;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  bit ras_prev = 1;
  int cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, cur_mode = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ras_prev && !ras_n_o) begin
        falls++;
        chk(ras_high_run >= T_RP, "R10 precharge", ras_high_run, T_RP);
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected refresh", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          cur_mode = e.mode;
          if (e.mode == 0) begin
            chk(cas_n_o == 0 && cas_low_run >= T_CSR, "R7 CAS lead", cas_low_run, T_CSR);
            chk(row_en_o == 0, "R7 no address", row_en_o, 0);
          end else if (e.mode == 1) begin
            chk(cas_n_o == 1 && row_en_o == 1, "R8 strobes", {cas_n_o, row_en_o}, 3);
            chk(int'(row_o) == e.row, "R8 row", row_o, e.row);
          end else begin
            chk(cas_n_o == 0 && cas_low_run >= T_RP, "R9 CAS held", cas_low_run, T_RP);
          end
        end
      end
      if (!ras_prev && ras_n_o) begin
        chk(ras_low_run == T_RAS, "R10 RAS width", ras_low_run, T_RAS);
        if (cur_mode == 2) chk(cas_n_o == 0, "R9 CAS at RAS rise", cas_n_o, 0);
      end
      if (!ras_n_o && cur_mode == 1 && cas_n_o == 0) chk(0, "R8 CAS low", 0, 1);
    end
    cas_low_run  = cas_n_o ? 0 : cas_low_run + 1;
    ras_low_run  = ras_n_o ? 0 : ras_low_run + 1;
    ras_high_run = ras_n_o ? ras_high_run + 1 : 0;
    ras_prev     = ras_n_o;
  end

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_falls(input int n);
    int t = 0;
    while (falls < n && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic measure(input int expv, input string req);
    int p, n, t;
    t = 0; p = pending_o;
    while (pending_o == p && t < 1000) begin @(negedge clk); t++; end
    p = pending_o; n = 0;
    while (n < 1000) begin
      @(negedge clk); n++;
      if (pending_o != p) break;
    end
    chk(n == expv, req, n, expv);
  endtask

  task automatic do_reset();
    rst = 1; tick_n(3); rst = 0; @(negedge clk);
  endtask

  task automatic reset_checks();
    chk(ras_n_o && cas_n_o, "R1 strobes idle", {ras_n_o, cas_n_o}, 3);
    chk(!row_en_o && !ref_req_o && !force_close_o, "R1 flags",
        {row_en_o, ref_req_o, force_close_o}, 0);
    chk(pending_o == 0 && row_o == 0, "R1 counters", pending_o, 0);
  endtask

  initial begin
    rst = 1;
    tick_n(3);
    reset_checks();
    rst = 0;
    // R2: CBR interval
    measure(IV_CBR, "R2 CBR interval");
    // fill to saturation, mark tick phase
    while (pending_o != BURST) @(negedge clk);
    chk(force_close_o == 1, "R5 force close", force_close_o, 1);
    chk(ref_req_o == 1, "R6 request", ref_req_o, 1);
    // grant while controller busy: nothing may start (R12)
    ref_gnt_i = 1; ctrl_idle_i = 0;
    tick_n(IV_CBR * 3 + 2);
    chk(pending_o == BURST, "R5 saturated", pending_o, BURST);
    chk(force_close_o == 1, "R5 force close held", force_close_o, 1);
    chk(falls == 0, "R12 no start while busy", falls, 0);
    // drain backlog with CBR cycles
    for (int i = 0; i < BURST; i++) push_exp(0, 0);
    ctrl_idle_i = 1;
    wait_falls(BURST);
    ref_gnt_i = 0;
    tick_n(T_RC + 4);
    chk(pending_o == 0, "R11 drained", pending_o, 0);
    chk(ref_req_o == 0, "R11 request low", ref_req_o, 0);
    chk(force_close_o == 0, "R5 force close drop", force_close_o, 0);
    // RAS-only cycles
    mode_i = 1;
    for (int i = 0; i < 3; i++) push_exp(1, i);
    ref_gnt_i = 1;
    wait_falls(BURST + 3);
    ref_gnt_i = 0;
    tick_n(T_RC + 4);
    chk(falls == BURST + 3, "R8 cycle count", falls, BURST + 3);
    chk(row_o == 3, "R8 row advance", row_o, 3);
    // hidden refresh
    mode_i = 2; ref_gnt_i = 1; ctrl_idle_i = 1; rd_hold_i = 0;
    while (pending_o == 0) @(negedge clk);
    tick_n(15);
    chk(falls == BURST + 3, "R9 wait for held read", falls, BURST + 3);
    push_exp(2, 0);
    rd_hold_i = 1;
    wait_falls(BURST + 4);
    rd_hold_i = 0; ref_gnt_i = 0;
    tick_n(T_RC + 4);
    chk(row_o == 3, "R9 row untouched", row_o, 3);
    chk(exp_q.size() == 0, "R6 all expected seen", exp_q.size(), 0);
    // RAS-only interval
    do_reset();
    reset_checks();
    mode_i = 1;
    measure(IV_ROR, "R3 RAS-only interval");
    // mode 3 acts as CBR
    do_reset();
    mode_i = 3;
    measure(IV_CBR, "R2 reserved mode interval");
    // low-power interval
    do_reset();
    mode_i = 0; low_pwr_i = 1;
    measure(2 * IV_CBR, "R4 low-power interval");
    chk(ras_n_o == 1, "R6 no cycle without grant", ras_n_o, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule